// File: doc/BRIEF.md
# Restore-Phase Atomic Memory Controller

This controller fronts a small byte-wide store whose read is destructive: sensing a location wipes it, so every access is a read phase followed by a restore phase that writes a byte back into the same location. The controller sequences both phases internally. The requester sees one indivisible access that no other request can split.

The restore phase is used to apply a simple operation with an implied operand to the byte that was just sensed. The requester supplies an address, optional write data and a 3-bit operation code under a valid/ready handshake. Increment, decrement, test-and-set (the lock primitive) and pointer auto-increment therefore cost no more bus traffic than a plain read. Each response carries the byte and a condition flag.

Top module: `rmw_core_ctrl`

## Requirements
- R1: Each accepted request first senses its location, which clears the stored byte to zero during the second cycle of the access. It then restores a byte into that same location at the end of that cycle.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the two cycles after that edge. On the third edge `req_ready` returns high and `rsp_valid` goes high for exactly one cycle, together with `rsp_data` and `rsp_flag`.
- R3: Opcode 000 (read) returns the stored byte and leaves it unchanged.
- R4: Opcode 001 (write) stores `req_wdata` and returns `req_wdata`.
- R5: Opcode 010 (increment) and opcode 011 (decrement) store the old byte plus or minus one, modulo 256, and return the old byte.
- R6: Opcode 100 (test-and-set) returns the old byte and stores 0xFF. `rsp_flag` is 1 exactly when the old byte was 0xFF, so a 0 flag means the lock was acquired. For every other opcode, `rsp_flag` is 0.
- R7: Opcode 101 (pointer auto-increment) returns the old byte and stores the old byte plus one, modulo 256.
- R8: Opcodes 110 and 111 behave exactly as a plain read.
- R9: While reset is active, and after it is released, `req_ready` is 1 and `rsp_valid` is 0 until a request is accepted.
- R10: A new request may be accepted on the edge that ends the cycle in which the previous response is presented. If it targets the same address, it senses the byte the previous request restored.
- R11: `req_valid`, `req_op`, `req_addr` and `req_wdata` are ignored while `req_ready` is low. The store contents and the response of the access in flight do not depend on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, able to accept |
| req_op | input | 3 | Operation code |
| req_addr | input | AW (4) | Byte address |
| req_wdata | input | DW (8) | Write data for opcode 001 |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DW (8) | Returned byte |
| rsp_flag | output | 1 | Test-and-set: old byte was all ones |

## Verification
Two events can fall in the same cycle. One is the presentation of a response. The other is the acceptance of the next request, which may go to the location that was just restored. The bench provokes this by issuing every request the moment the previous response is seen, with no idle gap, across long random runs with few addresses. It also runs directed increment and test-and-set chains on one address. Each response is judged against a bench model of the store, so a wrong restored value or a stale sense shows up in the returned byte or the flag.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_READ   = 3'b000,
    OP_WRITE  = 3'b001,
    OP_INC    = 3'b010,
    OP_DEC    = 3'b011,
    OP_TSET   = 3'b100,
    OP_PTRINC = 3'b101
  } rmw_op_e;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'b00,
    PH_SENSE   = 2'b01,
    PH_RESTORE = 2'b10
  } rmw_phase_e;
endpackage

// File: rtl/rmw_store.sv
module rmw_store #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] word_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    logic          cell_en;
    logic [DW-1:0] cell_q;
    assign cell_en = we && (addr == AW'(gi));
    always_ff @(posedge clk) begin
      if (cell_en) cell_q <= wdata;
    end
    assign word_q[gi] = cell_q;
  end

  assign rdata = word_q[addr];
endmodule

// File: rtl/rmw_restore_alu.sv
module rmw_restore_alu
  import rmw_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   old_val,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   restore_val,
  output logic [DW-1:0]   resp_val,
  output logic            resp_flag
);
  localparam logic [DW-1:0] ONE  = DW'(1);
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  always_comb begin
    restore_val = old_val;
    resp_val    = old_val;
    resp_flag   = 1'b0;
    case (op)
      OP_WRITE: begin
        restore_val = wdata;
        resp_val    = wdata;
      end
      OP_INC:    restore_val = old_val + ONE;
      OP_DEC:    restore_val = old_val - ONE;
      OP_TSET: begin
        restore_val = ONES;
        resp_flag   = (old_val == ONES);
      end
      OP_PTRINC: restore_val = old_val + ONE;
      default:   restore_val = old_val;
    endcase
  end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [OP_W-1:0] req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   alu_restore,
  input  logic [DW-1:0]   alu_resp,
  input  logic            alu_flag,
  output logic [OP_W-1:0] op_q,
  output logic [DW-1:0]   old_q,
  output logic [DW-1:0]   wdata_q,
  output logic            in_restore,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  output logic            rsp_flag
);
  rmw_phase_e    phase_q, phase_d;
  logic [AW-1:0] addr_q;
  logic          accept, cap_req, cap_old, cap_rsp;

  assign req_ready  = (phase_q == PH_IDLE);
  assign accept     = req_valid && req_ready;
  assign in_restore = (phase_q == PH_RESTORE);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:    if (accept) phase_d = PH_SENSE;
      PH_SENSE:   phase_d = PH_RESTORE;
      PH_RESTORE: phase_d = PH_IDLE;
      default:    phase_d = PH_IDLE;
    endcase
  end

  assign cap_req = accept;
  assign cap_old = (phase_q == PH_SENSE);
  assign cap_rsp = (phase_q == PH_RESTORE);

  assign mem_addr  = addr_q;
  assign mem_we    = (phase_q == PH_SENSE) || (phase_q == PH_RESTORE);
  assign mem_wdata = (phase_q == PH_SENSE) ? '0 : alu_restore;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      rsp_valid <= cap_rsp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_req) begin
      op_q    <= req_op;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) old_q <= '0;
    else if (cap_old) old_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data <= '0;
      rsp_flag <= 1'b0;
    end else if (cap_rsp) begin
      rsp_data <= alu_resp;
      rsp_flag <= alu_flag;
    end
  end

  // R2: accepted request makes the controller busy on the next cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!req_ready && phase_q == PH_SENSE));
  // R2: sense is always followed by restore
  a_r2_sense_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SENSE) |=> (phase_q == PH_RESTORE && !req_ready));
  // R2: restore ends with idle and a response strobe
  a_r2_restore_done: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RESTORE) |=> (req_ready && rsp_valid));
  // R2: response strobe lasts one cycle
  a_r2_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R11: latched request fields stay put while busy
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RESTORE) |-> ($stable(addr_q) && $stable(op_q) && $stable(wdata_q)));
endmodule

// File: rtl/rmw_core_ctrl.sv
module rmw_core_ctrl
  import rmw_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [OP_W-1:0] req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  output logic            rsp_flag
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            mem_we;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata, mem_rdata;
  logic [DW-1:0]   alu_restore, alu_resp;
  logic            alu_flag;
  logic [OP_W-1:0] op_q;
  logic [DW-1:0]   old_q, wdata_q;
  logic            in_restore;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rmw_store #(.AW(AW), .DW(DW)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  rmw_restore_alu #(.DW(DW)) u_alu (
    .op          (op_q),
    .old_val     (old_q),
    .wdata       (wdata_q),
    .restore_val (alu_restore),
    .resp_val    (alu_resp),
    .resp_flag   (alu_flag)
  );

  rmw_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .mem_rdata   (mem_rdata),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .alu_restore (alu_restore),
    .alu_resp    (alu_resp),
    .alu_flag    (alu_flag),
    .op_q        (op_q),
    .old_q       (old_q),
    .wdata_q     (wdata_q),
    .in_restore  (in_restore),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_flag    (rsp_flag)
  );

  // R1: during restore the sensed location reads back as cleared
  a_r1_cleared: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_restore |-> (mem_rdata == '0));
  // R6: test-and-set leaves all ones behind
  a_r6_tset_ones: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_restore && op_q == OP_TSET) |=> (mem_rdata == {DW{1'b1}}));
  // R5: increment restores old plus one
  a_r5_inc_restore: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_restore && op_q == OP_INC) |=> (mem_rdata == $past(old_q) + DW'(1)));
  // R4: write leaves the write data behind and returns it
  a_r4_write_restore: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_restore && op_q == OP_WRITE) |=> (mem_rdata == $past(wdata_q) && rsp_data == $past(wdata_q)));
  // R3: plain read leaves the sensed byte unchanged
  a_r3_read_keeps: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_restore && op_q == OP_READ) |=> (mem_rdata == $past(old_q)));
endmodule

// File: tb/rmw_core_ctrl_bench.sv
`timescale 1ns/1ps
module rmw_core_ctrl_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          rsp_flag;

  int checks;
  int failures;
  logic [DW-1:0] model [DEPTH];
  bit finished;

  rmw_core_ctrl #(.AW(AW), .DW(DW)) u_rmw_core_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_flag  (rsp_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [DW-1:0] exp_store(input logic [2:0] op, input logic [DW-1:0] old, input logic [DW-1:0] wd);
    case (op)
      3'b001: return wd;
      3'b010: return old + 8'd1;
      3'b011: return old - 8'd1;
      3'b100: return 8'hFF;
      3'b101: return old + 8'd1;
      default: return old;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_data(input logic [2:0] op, input logic [DW-1:0] old, input logic [DW-1:0] wd);
    return (op == 3'b001) ? wd : old;
  endfunction

  function automatic logic exp_flag(input logic [2:0] op, input logic [DW-1:0] old);
    return (op == 3'b100) && (old == 8'hFF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Entered at a negedge with the controller idle; leaves at the negedge
  // where the response is visible, so the next call is back-to-back (R10).
  task automatic access(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input bit noise, input string tag);
    logic [DW-1:0] old;
    old = model[a];
    check("R2 ready before accept", req_ready, 1'b1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    if (noise) begin
      req_valid = 1'b1; req_op = 3'($urandom); req_addr = AW'($urandom); req_wdata = DW'($urandom);
    end else req_valid = 1'b0;
    check("R2 ready low cycle 1", req_ready, 1'b0);
    check("R2 no rsp cycle 1", rsp_valid, 1'b0);
    @(negedge clk);
    if (noise) begin
      req_op = 3'($urandom); req_addr = AW'($urandom); req_wdata = DW'($urandom);
    end
    check("R2 ready low cycle 2", req_ready, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 rsp strobe", rsp_valid, 1'b1);
    check("R2 ready back", req_ready, 1'b1);
    check({tag, " data"}, rsp_data, exp_data(op, old, wd));
    check({tag, " flag R6"}, rsp_flag, exp_flag(op, old));
    model[a] = exp_store(op, old, wd);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int seed_dummy;
    checks = 0; failures = 0; finished = 1'b0;
    seed_dummy = $urandom(32'h5EED);
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check("R9 ready in reset", req_ready, 1'b1);
    check("R9 rsp idle in reset", rsp_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 ready after reset", req_ready, 1'b1);
    check("R9 rsp idle after reset", rsp_valid, 1'b0);

    for (int i = 0; i < DEPTH; i++) access(3'b001, AW'(i), DW'(8'h30 + i), 1'b0, "R4 fill");
    for (int i = 0; i < DEPTH; i++) access(3'b000, AW'(i), 8'h00, 1'b0, "R1 R3 read");
    for (int i = 0; i < DEPTH; i++) access(3'b000, AW'(i), 8'h00, 1'b0, "R1 R3 reread");

    access(3'b001, 4'd3, 8'h10, 1'b0, "R4 write");
    access(3'b010, 4'd3, 8'h00, 1'b0, "R5 inc");
    access(3'b010, 4'd3, 8'h00, 1'b0, "R10 inc back-to-back");
    access(3'b000, 4'd3, 8'h00, 1'b0, "R10 read restored");
    access(3'b001, 4'd4, 8'hFF, 1'b0, "R4 write ff");
    access(3'b010, 4'd4, 8'h00, 1'b0, "R5 inc wrap");
    access(3'b011, 4'd4, 8'h00, 1'b0, "R5 dec wrap");
    access(3'b011, 4'd4, 8'h00, 1'b0, "R5 dec");
    access(3'b001, 4'd5, 8'h00, 1'b0, "R4 write lock free");
    access(3'b100, 4'd5, 8'h00, 1'b0, "R6 tset acquire");
    access(3'b100, 4'd5, 8'h00, 1'b0, "R6 tset busy");
    access(3'b000, 4'd5, 8'h00, 1'b0, "R6 read after tset");
    access(3'b001, 4'd6, 8'hFE, 1'b0, "R4 write ptr");
    access(3'b101, 4'd6, 8'h00, 1'b0, "R7 ptr walk");
    access(3'b101, 4'd6, 8'h00, 1'b0, "R7 ptr wrap");
    access(3'b101, 4'd6, 8'h00, 1'b0, "R7 ptr after wrap");
    access(3'b110, 4'd6, 8'hAA, 1'b0, "R8 op110");
    access(3'b111, 4'd6, 8'h55, 1'b0, "R8 op111");
    access(3'b000, 4'd6, 8'h00, 1'b0, "R8 unchanged");
    access(3'b001, 4'd7, 8'h5A, 1'b1, "R11 write with noise");
    access(3'b000, 4'd7, 8'h00, 1'b1, "R11 read with noise");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom);
      access(op, AW'($urandom % 4), DW'($urandom), 1'($urandom), "R10 R11 random");
    end

    for (int i = 0; i < DEPTH; i++) access(3'b000, AW'(i), 8'h00, 1'b0, "R3 final sweep");

    @(negedge clk);
    check("R2 idle no rsp", rsp_valid, 1'b0);
    finish_run();
  end
endmodule